// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target holds stuck: SDA is low while SCL is high, so no master can begin a transfer. Software issues a one-cycle trigger. If SDA is already high, the block reports success at once and drives nothing. Otherwise it clocks SCL with open-drain pulses until the target lets go of SDA. It then forms a STOP condition and raises a success flag. If the pulse budget runs out with SDA still low, it releases both lines and raises a separate failure flag.

The engine is meant to run after the controller has been reset and re-enabled as the only master on the bus, with automatic bus release. The two outputs are pull-low enables for an open-drain pad. Each half of every SCL period, and each STOP phase, lasts a programmable number of clock cycles. The trigger status (`busy`) drops in the same cycle that the outcome flag rises. Both flags stay set until software clears them by writing a one.

Top module: `i2c_bus_unjam`

## Requirements
- R1: After reset, `scl_pull` and `sda_pull` are 0, `busy` is 0, and `flag_ok` and `flag_fail` are 0.
- R2: A trigger while `sda_in` is 1 sets `flag_ok` at the next clock edge. `busy` stays 0 and neither line is pulled.
- R3: A trigger while `sda_in` is 0 raises `busy`. SCL is then pulled low for P cycles and released for P cycles, repeatedly, where P is `half_period`.
- R4: SDA is sampled at the end of each released half, and only when `scl_in` reads 1. If `scl_in` reads 0 at that point, the released half is extended by another P cycles.
- R5: When the sample shows SDA high, the block pulls both lines low for P cycles, then releases SCL for P cycles, then releases SDA for P cycles, and then sets `flag_ok`. If the target frees SDA on the K-th rising SCL edge, a run lasts 2·K·P + 3·P cycles from the trigger edge and contains K+1 SCL low pulses.
- R6: If SDA is still low after MAX_PULSES (default 9) pulses, both lines are released and `flag_fail` is set, 2·MAX_PULSES·P cycles after the trigger edge.
- R7: `busy` falls in the same cycle that either outcome flag rises, and the two flags never rise together.
- R8: A flag stays set until its clear input is 1 at a clock edge. If a clear and a set of the same flag fall on the same edge, the set wins.
- R9: A trigger while `busy` is 1 has no effect on the run's outcome or length.
- R10: A `half_period` of 0 behaves exactly like 1.
- R11: `sda_pull` changes only while `scl_pull` is 1, except for the final release of SDA with SCL released, which forms the STOP condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| trigger | input | 1 | One-cycle recovery command |
| half_period | input | PW (8) | Cycles per SCL half and per STOP phase |
| clr_ok | input | 1 | Write-one clear of the success flag |
| clr_fail | input | 1 | Write-one clear of the failure flag |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| busy | output | 1 | Trigger status, high while a recovery runs |
| flag_ok | output | 1 | Recovery succeeded (sticky) |
| flag_fail | output | 1 | Recovery failed (sticky) |

## Verification
Two functions can fall in the same cycle: software's write-one clear of the success flag and the engine setting that flag at the close of the STOP. The bench places `clr_ok` on exactly the edge where the flag rises, which it computes from 2·K·P + 3·P. It then requires the flag to read 1 after that edge and 0 after a later clear. A second overlap is a fresh trigger that arrives while a run is still in progress. The bench judges it by checking that the run's length and outcome are unchanged. All other runs sweep the release pulse K from 0 to 10 against periods 0 to 3 and compare the cycle count, the outcome and the number of SCL low pulses with arithmetic expectations.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } rcv_state_e;
endpackage

// File: rtl/rcv_tick.sv
// Phase timer: one tick every max(period,1) cycles while running.
module rcv_tick #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [PW-1:0] period,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } tick_t;

    tick_t         t_d, t_q;
    logic [PW-1:0] per_eff;

    always_comb begin
        per_eff = (period == '0) ? PW'(1) : period;   // R10
        tick    = !hold && (t_q.cnt == per_eff - PW'(1));
        t_d     = t_q;
        if (hold || tick) t_d.cnt = '0;
        else              t_d.cnt = t_q.cnt + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/rcv_seq.sv
// Recovery sequencer: pulses, SDA sampling, STOP and sticky outcome flags.
module rcv_seq
    import rcv_pkg::*;
#(
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trigger,
    input  logic scl_in,
    input  logic sda_in,
    input  logic clr_ok,
    input  logic clr_fail,
    output logic timer_hold,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic flag_ok,
    output logic flag_fail
);
    localparam int CW = $clog2(MAX_PULSES + 1);

    typedef struct packed {
        rcv_state_e    state;
        logic [CW-1:0] pulses;
        logic          ok;
        logic          fail;
    } seq_t;

    seq_t s_d, s_q;
    logic set_ok, set_fail;

    always_comb begin
        s_d      = s_q;
        set_ok   = 1'b0;
        set_fail = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (trigger) begin
                    if (sda_in) begin
                        set_ok = 1'b1;                 // R2: bus already free
                    end else begin
                        s_d.state  = ST_LOW;           // R3
                        s_d.pulses = '0;
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    s_d.state  = ST_HIGH;
                    s_d.pulses = s_q.pulses + CW'(1);
                end
            end
            ST_HIGH: begin
                if (tick && scl_in) begin              // R4: sample only with SCL high
                    if (sda_in) begin
                        s_d.state = ST_STOP_A;         // R5
                    end else if (s_q.pulses == CW'(MAX_PULSES)) begin
                        set_fail  = 1'b1;              // R6
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.state = ST_LOW;
                    end
                end
            end
            ST_STOP_A: if (tick) s_d.state = ST_STOP_B;
            ST_STOP_B: if (tick) s_d.state = ST_STOP_C;
            ST_STOP_C: begin
                if (tick) begin
                    set_ok    = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
        s_d.ok   = (s_q.ok   && !clr_ok)   || set_ok;   // R8: set wins
        s_d.fail = (s_q.fail && !clr_fail) || set_fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state  <= ST_IDLE;
            s_q.pulses <= '0;
            s_q.ok     <= 1'b0;
            s_q.fail   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign timer_hold = (s_q.state == ST_IDLE);
    assign busy       = (s_q.state != ST_IDLE);
    assign scl_pull   = (s_q.state == ST_LOW) || (s_q.state == ST_STOP_A);
    assign sda_pull   = (s_q.state == ST_STOP_A) || (s_q.state == ST_STOP_B);
    assign flag_ok    = s_q.ok;
    assign flag_fail  = s_q.fail;
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
    parameter int PW         = 8,
    parameter int MAX_PULSES = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          trigger,
    input  logic [PW-1:0] half_period,
    input  logic          clr_ok,
    input  logic          clr_fail,
    output logic          scl_pull,
    output logic          sda_pull,
    output logic          busy,
    output logic          flag_ok,
    output logic          flag_fail
);
    logic tick;
    logic timer_hold;

    rcv_tick #(.PW(PW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (timer_hold),
        .period (half_period),
        .tick   (tick)
    );

    rcv_seq #(.MAX_PULSES(MAX_PULSES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .trigger    (trigger),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .clr_ok     (clr_ok),
        .clr_fail   (clr_fail),
        .timer_hold (timer_hold),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .busy       (busy),
        .flag_ok    (flag_ok),
        .flag_fail  (flag_fail)
    );
endmodule

// File: rtl/rcv_checker.sv
module rcv_checker #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic trigger,
    input logic clr_ok,
    input logic scl_pull,
    input logic sda_pull,
    input logic busy,
    input logic flag_ok,
    input logic flag_fail
);
    logic [7:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     rise_cnt <= '0;
        else if (!busy)                 rise_cnt <= '0;
        else if (scl_pull && rise_cnt != 8'hff && !$past(scl_pull))
                                        rise_cnt <= rise_cnt + 8'd1;
    end

    // R6: never more SCL low pulses than the budget plus the STOP low
    p_pulse_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= 8'(MAX_PULSES + 1));

    // R7: trigger status drops with the outcome flag
    p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_ok) || $rose(flag_fail)) |-> !busy);

    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(flag_ok) && $rose(flag_fail)));

    // R11: SDA released with SCL released only as STOP; SDA pulled only with SCL pulled
    p_stop_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> scl_pull);

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull));

    // R8: a clear while nothing can set the flag empties it
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !busy && !trigger) |=> !flag_ok);
endmodule

bind i2c_bus_unjam rcv_checker #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigger   (trigger),
    .clr_ok    (clr_ok),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .busy      (busy),
    .flag_ok   (flag_ok),
    .flag_fail (flag_fail)
);

// File: tb/tb_i2c_bus_unjam.sv
`timescale 1ns/1ps
module tb_i2c_bus_unjam;
    localparam int PW    = 8;
    localparam int NMAX  = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trigger = 1'b0;
    logic [PW-1:0] half_period = '0;
    logic          clr_ok = 1'b0;
    logic          clr_fail = 1'b0;
    logic          scl_pull, sda_pull, busy, flag_ok, flag_fail;
    logic          ext_low = 1'b0;
    logic          tgt_rst = 1'b0;
    int            rel_k = 0;
    int            seen = 0;
    int            lows = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    int            wd = 0;

    wire scl_line = !scl_pull && !ext_low;
    wire sda_line = !sda_pull && !(seen < rel_k);

    always #2 clk = !clk;   // 250 MHz

    i2c_bus_unjam #(.PW(PW), .MAX_PULSES(NMAX)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .trigger(trigger), .half_period(half_period),
        .clr_ok(clr_ok), .clr_fail(clr_fail),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy),
        .flag_ok(flag_ok), .flag_fail(flag_fail)
    );

    // Target model: releases SDA on the rel_k-th rising SCL edge.
    always @(posedge scl_line or posedge tgt_rst) begin
        if (tgt_rst) seen <= 0;
        else         seen <= seen + 1;
    end
    always @(negedge scl_line or posedge tgt_rst) begin
        if (tgt_rst) lows <= 0;
        else         lows <= lows + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act %0d exp <150000 cycles", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    // Trigger at edge E0; cyc = edges after E0 until a flag is seen.
    task automatic launch(input int p, input int k, input int second_at,
                          output int cyc, output bit ok, output bit fl, output bit bsy);
        @(negedge clk);
        half_period = PW'(p);
        rel_k       = k;
        tgt_rst     = 1'b1;
        #0.1 tgt_rst = 1'b0;
        trigger     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trigger = 1'b0;
        cyc = 0;
        while (!(flag_ok || flag_fail) && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            trigger = (cyc == second_at);
        end
        trigger = 1'b0;
        ok  = flag_ok;
        fl  = flag_fail;
        bsy = busy;
        clr_ok   = 1'b1;
        clr_fail = 1'b1;
        @(negedge clk);
        clr_ok   = 1'b0;
        clr_fail = 1'b0;
    endtask

    initial begin
        int cyc; bit ok; bit fl; bit bsy;
        repeat (3) @(negedge clk);
        chk(!scl_pull && !sda_pull && !busy && !flag_ok && !flag_fail,
            "R1 reset state", {scl_pull, sda_pull, busy, flag_ok, flag_fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: period 0..3 (0 acts as 1, R10), release pulse 0..10
        for (int p = 0; p <= 3; p++) begin
            for (int k = 0; k <= 10; k++) begin
                int pe, exp_cyc, exp_lows;
                pe = (p == 0) ? 1 : p;
                if (k == 0)         begin exp_cyc = 0;              exp_lows = 0;      end
                else if (k <= NMAX) begin exp_cyc = 2*k*pe + 3*pe;  exp_lows = k + 1;  end
                else                begin exp_cyc = 2*NMAX*pe;      exp_lows = NMAX;   end
                launch(p, k, -1, cyc, ok, fl, bsy);
                if (k == 0) begin
                    chk(cyc == 0 && ok, "R2 immediate success", cyc, 0);
                    chk(lows == 0, "R2 no SCL pulses", lows, 0);
                end else if (k <= NMAX) begin
                    chk(ok && !fl, "R5 success outcome", {ok, fl}, 2);
                    chk(cyc == exp_cyc, (p == 0) ? "R10 period zero length" : "R5 run length",
                        cyc, exp_cyc);
                    chk(lows == exp_lows, "R3 SCL low pulse count", lows, exp_lows);
                    chk(sda_line, "R11 SDA free after STOP", sda_line, 1);
                end else begin
                    chk(fl && !ok, "R6 failure outcome", {ok, fl}, 1);
                    chk(cyc == exp_cyc, "R6 run length", cyc, exp_cyc);
                    chk(lows == exp_lows, "R6 pulse budget", lows, exp_lows);
                    chk(!scl_pull && !sda_pull, "R6 lines released",
                        {scl_pull, sda_pull}, 0);
                end
                chk(!bsy, "R7 busy low with flag", bsy, 0);
                chk(!flag_ok && !flag_fail, "R8 flags cleared by write",
                    {flag_ok, flag_fail}, 0);
            end
        end

        // R9: second trigger mid-run ignored (P=1, K=3 -> 9 cycles)
        launch(1, 3, 4, cyc, ok, fl, bsy);
        chk(cyc == 9 && ok, "R9 retrigger ignored", cyc, 9);

        // R4: SCL held low externally over the first sample point (P=2, K=1 -> 12)
        @(negedge clk);
        half_period = PW'(2);
        rel_k = 1;
        tgt_rst = 1'b1;
        #0.1 tgt_rst = 1'b0;
        ext_low = 1'b1;
        trigger = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trigger = 1'b0;
        cyc = 0;
        while (!(flag_ok || flag_fail) && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 4) ext_low = 1'b0;
        end
        chk(cyc == 12 && flag_ok, "R4 stretched sample", cyc, 12);
        clr_ok = 1'b1;
        @(negedge clk);
        clr_ok = 1'b0;

        // R8: clear on the same edge as the set (P=1, K=1 -> set at edge E0+5)
        @(negedge clk);
        half_period = PW'(1);
        rel_k = 1;
        tgt_rst = 1'b1;
        #0.1 tgt_rst = 1'b0;
        trigger = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trigger = 1'b0;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        chk(!flag_ok && busy, "R8 not yet set", flag_ok, 0);
        clr_ok = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(flag_ok == 1'b1, "R8 set wins over clear", flag_ok, 1);
        @(negedge clk);
        clr_ok = 1'b0;
        chk(flag_ok == 1'b0, "R8 later clear", flag_ok, 0);

        // R8: sticky without clear
        launch(1, 0, -1, cyc, ok, fl, bsy);
        @(negedge clk);
        half_period = PW'(1);
        rel_k = 0;
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        repeat (5) @(negedge clk);
        chk(flag_ok == 1'b1, "R8 flag sticky", flag_ok, 1);
        clr_ok = 1'b1;
        @(negedge clk);
        clr_ok = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule